// File: doc/BRIEF.md
# Single-Channel PWM Generator with Staged Updates

This block produces one pulse-width-modulated output from a free-running cycle counter. Software programs a period length, a duty length and a control word over a simple APB-style register bus. While the channel runs, the counter steps once per clock from zero up to the period minus one and then wraps. The output takes a programmable "duty" level for the first `duty` counts of each period and a programmable "inactive" level for the rest.

New period and duty values written by software go into holding copies. The waveform only picks them up at a period boundary, so a period is never cut short or stretched mid-way. A hold bit in the control word lets software rewrite period, duty and both output levels in several bus transfers. On release, all of them take effect together at the first boundary that follows. Only continuous, left-aligned operation is built. Disabling the channel parks the counter at zero and drives the inactive level.

Top module: `pwm_lockstep`

## Requirements
- R1: Bus offsets are fixed: 0x00 counter (read-only, writes have no effect), 0x04 period, 0x08 duty, 0x0C control. Period and duty read back the last written 32-bit value. Control reads back only bit 0 (enable), bit 1 (continuous), bit 3 (duty level), bit 4 (inactive level) and bit 6 (hold), with all other bits zero.
- R2: The channel runs only when control bits 0 and 1 are both 1. Otherwise the counter reads 0 and the output equals control bit 4.
- R3: While running, the counter advances by one per clock and wraps to 0 after reaching period minus one.
- R4: While running, the output equals the active duty level while count < duty and the active inactive level otherwise. A duty of 0 therefore gives a constant inactive level, duty ≥ period gives a constant duty level, and a period of 0 gives the inactive level.
- R5: The control write that starts the channel loads the held period, duty and both levels at once. The first clock after that write shows count 0.
- R6: With hold clear, period and duty writes made during a period reach the waveform only when the counter wraps to 0.
- R7: While hold (control bit 6) is 1, writes to period, duty and the two level bits do not change the running waveform.
- R8: After hold is cleared, the held period, duty and level bits all take effect together at the next wrap to count 0 and never before it.
- R9: Every bus access completes in its access phase with ready high and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| pwm_out | output | 1 | PWM waveform |

## Verification
A sweep enables the channel with every period from 0 to 5 and every duty from 0 to 6, under all four combinations of the two level bits. Each output sample is compared with a count derived from the cycle of the enable write. This separates the zero-duty, full-duty and zero-period cases and catches swapped or shorted level bits. A long period is then rewritten mid-period without hold, which shows whether the new value lands early or only at the wrap. A hold sequence changes period, duty and both levels at once. The bench predicts the exact wrap after release, so a change that arrives one cycle early, one period late, or piecemeal across the three fields is caught.

// File: rtl/pwm_lk_pkg.sv
package pwm_lk_pkg;
    localparam logic [1:0] SEL_CNT = 2'd0;
    localparam logic [1:0] SEL_PER = 2'd1;
    localparam logic [1:0] SEL_DUT = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    localparam int B_EN    = 0;
    localparam int B_CONT  = 1;
    localparam int B_DLVL  = 3;
    localparam int B_ILVL  = 4;
    localparam int B_HOLD  = 6;

    typedef struct packed {
        logic en;
        logic cont;
        logic dlvl;
        logic ilvl;
        logic hold;
    } ctl_t;
endpackage

// File: rtl/pwm_lk_regs.sv
module pwm_lk_regs
    import pwm_lk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] cnt_i,
    output logic [DATA_W-1:0] prdata,
    output logic [DATA_W-1:0] sh_per_o,
    output logic [DATA_W-1:0] sh_dut_o,
    output ctl_t              ctl_o,
    output logic              run_nxt_o,
    output logic              dlvl_nxt_o,
    output logic              ilvl_nxt_o
);
    typedef struct packed {
        logic [DATA_W-1:0] per;
        logic [DATA_W-1:0] dut;
        ctl_t              ctl;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic       hit;
    logic [1:0] sel;
    logic [DATA_W-1:0] ctl_word;

    always_comb begin
        hit = (paddr[ADDR_W-1:4] == '0) && (paddr[1:0] == 2'b00);
        sel = paddr[3:2];
        st_d = st_q;
        if (psel && penable && pwrite && hit) begin
            case (sel)
                SEL_PER: st_d.per = pwdata;
                SEL_DUT: st_d.dut = pwdata;
                SEL_CTL: begin
                    st_d.ctl.en   = pwdata[B_EN];
                    st_d.ctl.cont = pwdata[B_CONT];
                    st_d.ctl.dlvl = pwdata[B_DLVL];
                    st_d.ctl.ilvl = pwdata[B_ILVL];
                    st_d.ctl.hold = pwdata[B_HOLD];
                end
                default: ;
            endcase
        end
        ctl_word = '0;
        ctl_word[B_EN]   = st_q.ctl.en;
        ctl_word[B_CONT] = st_q.ctl.cont;
        ctl_word[B_DLVL] = st_q.ctl.dlvl;
        ctl_word[B_ILVL] = st_q.ctl.ilvl;
        ctl_word[B_HOLD] = st_q.ctl.hold;
        prdata = '0;
        if (psel && !pwrite && hit) begin
            case (sel)
                SEL_CNT: prdata = cnt_i;
                SEL_PER: prdata = st_q.per;
                SEL_DUT: prdata = st_q.dut;
                default: prdata = ctl_word;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sh_per_o   = st_q.per;
    assign sh_dut_o   = st_q.dut;
    assign ctl_o      = st_q.ctl;
    assign run_nxt_o  = st_d.ctl.en && st_d.ctl.cont;
    assign dlvl_nxt_o = st_d.ctl.dlvl;
    assign ilvl_nxt_o = st_d.ctl.ilvl;

    // R1: the period holding copy changes only through a period write
    p_per_write_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> $stable(st_q.per));
endmodule

// File: rtl/pwm_lk_core.sv
module pwm_lk_core
    import pwm_lk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl_i,
    input  logic              run_nxt_i,
    input  logic              dlvl_nxt_i,
    input  logic              ilvl_nxt_i,
    input  logic [DATA_W-1:0] sh_per_i,
    input  logic [DATA_W-1:0] sh_dut_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              pwm_o
);
    localparam logic [DATA_W:0] ONE = {{DATA_W{1'b0}}, 1'b1};

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] aper;
        logic [DATA_W-1:0] adut;
        logic              adlvl;
        logic              ailvl;
    } core_st_t;

    core_st_t st_d, st_q;
    logic          run_now;
    logic [DATA_W:0] cnt_inc;
    logic          wrap;

    always_comb begin
        run_now = ctl_i.en && ctl_i.cont;
        cnt_inc = {1'b0, st_q.cnt} + ONE;
        wrap    = cnt_inc >= {1'b0, st_q.aper};
        st_d    = st_q;
        if (!run_nxt_i) begin
            st_d.cnt = '0;
        end else if (!run_now) begin
            st_d.cnt   = '0;
            st_d.aper  = sh_per_i;
            st_d.adut  = sh_dut_i;
            st_d.adlvl = dlvl_nxt_i;
            st_d.ailvl = ilvl_nxt_i;
        end else if (wrap) begin
            st_d.cnt = '0;
            if (!ctl_i.hold) begin
                st_d.aper  = sh_per_i;
                st_d.adut  = sh_dut_i;
                st_d.adlvl = ctl_i.dlvl;
                st_d.ailvl = ctl_i.ilvl;
            end
        end else begin
            st_d.cnt = cnt_inc[DATA_W-1:0];
        end

        if (!run_now)                 pwm_o = ctl_i.ilvl;
        else if (st_q.aper == '0)     pwm_o = st_q.ailvl;
        else if (st_q.cnt < st_q.adut) pwm_o = st_q.adlvl;
        else                          pwm_o = st_q.ailvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    p_stopped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_i.en && ctl_i.cont) |-> st_q.cnt == '0);
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.en && ctl_i.cont && st_q.aper != '0) |-> st_q.cnt < st_q.aper);
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_i.en && ctl_i.cont) && st_q.cnt != '0) |-> st_q.cnt == $past(st_q.cnt) + 1'b1);
    p_midperiod_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_i.en && ctl_i.cont) && st_q.cnt != '0) |->
        ($stable(st_q.aper) && $stable(st_q.adut) && $stable(st_q.adlvl) && $stable(st_q.ailvl)));
    p_hold_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_i.en && ctl_i.cont) && $past(ctl_i.hold)) |->
        ($stable(st_q.aper) && $stable(st_q.adut) && $stable(st_q.adlvl) && $stable(st_q.ailvl)));
endmodule

// File: rtl/pwm_lockstep.sv
module pwm_lockstep
    import pwm_lk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              pwm_out
);
    logic [DATA_W-1:0] sh_per, sh_dut, cnt;
    ctl_t ctl;
    logic run_nxt, dlvl_nxt, ilvl_nxt;

    pwm_lk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .cnt_i(cnt), .prdata(prdata),
        .sh_per_o(sh_per), .sh_dut_o(sh_dut), .ctl_o(ctl),
        .run_nxt_o(run_nxt), .dlvl_nxt_o(dlvl_nxt), .ilvl_nxt_o(ilvl_nxt)
    );

    pwm_lk_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .run_nxt_i(run_nxt),
        .dlvl_nxt_i(dlvl_nxt), .ilvl_nxt_i(ilvl_nxt),
        .sh_per_i(sh_per), .sh_dut_i(sh_dut), .cnt_o(cnt), .pwm_o(pwm_out)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.en && ctl.cont) |-> pwm_out == ctl.ilvl);
endmodule

// File: tb/pwm_lockstep_test.sv
module pwm_lockstep_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, pwm_out;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    localparam logic [11:0] A_CNT = 12'h000, A_PER = 12'h004, A_DUT = 12'h008, A_CTL = 12'h00C;

    pwm_lockstep uut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .pwm_out(pwm_out));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = v;
        @(negedge clk); penable = 1;
        #1 chk(pready === 1'b1 && pslverr === 1'b0, "R9 write", {pready, pslverr}, 32'h2);
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v, output int at);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 v = prdata; at = cyc;
        chk(pready === 1'b1 && pslverr === 1'b0, "R9 read", {pready, pslverr}, 32'h2);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    function automatic bit expo(input int rel, input int p, input int d, input bit dh, input bit ih);
        if (p == 0) return ih;
        return ((rel % p) < d) ? dh : ih;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int at, c0, u, nb;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk(pwm_out === 1'b0, "R2 reset output", pwm_out, 0);
        rd(A_CTL, v, at); chk(v === 32'h0, "R1 reset control", v, 0);
        rd(A_CNT, v, at); chk(v === 32'h0, "R2 reset counter", v, 0);

        // R1 register readback and read-only counter
        wr(A_PER, 32'hA5A5_0003); rd(A_PER, v, at); chk(v === 32'hA5A5_0003, "R1 period", v, 32'hA5A5_0003);
        wr(A_DUT, 32'h1234_5678); rd(A_DUT, v, at); chk(v === 32'h1234_5678, "R1 duty", v, 32'h1234_5678);
        wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, v, at); chk(v === 32'h5B, "R1 control mask", v, 32'h5B);
        wr(A_CTL, 32'h0);
        wr(A_CNT, 32'h7); rd(A_CNT, v, at); chk(v === 32'h0, "R1 counter ignores writes", v, 0);

        // R2 enable alone (no continuous) keeps the channel stopped
        wr(A_PER, 3); wr(A_DUT, 2); wr(A_CTL, 32'h11);
        for (int k = 0; k < 6; k++) begin
            chk(pwm_out === 1'b1, "R2 enable without continuous", pwm_out, 1);
            @(negedge clk);
        end
        rd(A_CNT, v, at); chk(v === 0, "R2 counter held", v, 0);
        wr(A_CTL, 32'h0);

        // R3 R4 R5 sweep
        for (int p = 0; p <= 5; p++)
            for (int d = 0; d <= 6; d++)
                for (int pm = 0; pm < 4; pm++) begin
                    bit dh, ih;
                    dh = pm[0]; ih = pm[1];
                    wr(A_CTL, {27'd0, ih, dh, 3'd0});
                    chk(pwm_out === ih, "R2 stopped idle level", pwm_out, ih);
                    wr(A_PER, p); wr(A_DUT, d);
                    wr(A_CTL, {27'd0, ih, dh, 3'b011});
                    c0 = cyc;
                    for (int k = 0; k < 2 * p + 3; k++) begin
                        bit e;
                        e = expo(cyc - c0, p, d, dh, ih);
                        chk(pwm_out === e, "R4 R5 waveform", pwm_out, e);
                        @(negedge clk);
                    end
                    if (p == 4 && d == 1) begin
                        rd(A_CNT, v, at);
                        chk(v === (at - c0) % 4, "R3 counter readback", v, (at - c0) % 4);
                    end
                    wr(A_CTL, 32'h0);
                end

        // R6 unlocked mid-period rewrite waits for the wrap
        wr(A_PER, 20); wr(A_DUT, 10); wr(A_CTL, 32'h0B);
        c0 = cyc;
        wr(A_PER, 6);
        while (cyc - c0 < 32) begin
            bit e;
            e = (cyc - c0 < 20) ? expo(cyc - c0, 20, 10, 1, 0) : 1'b1;
            chk(pwm_out === e, "R6 update at wrap", pwm_out, e);
            @(negedge clk);
        end
        rd(A_CNT, v, at);
        chk(v === (at - c0 - 20) % 6, "R3 R6 counter after rewrite", v, (at - c0 - 20) % 6);
        wr(A_CTL, 32'h0);

        // R7 R8 hold, then release
        wr(A_PER, 4); wr(A_DUT, 1); wr(A_CTL, 32'h0B);
        c0 = cyc;
        wr(A_CTL, 32'h4B);
        wr(A_PER, 8); wr(A_DUT, 5); wr(A_CTL, 32'h53);
        for (int k = 0; k < 12; k++) begin
            bit e;
            e = expo(cyc - c0, 4, 1, 1, 0);
            chk(pwm_out === e, "R7 held waveform", pwm_out, e);
            @(negedge clk);
        end
        rd(A_PER, v, at); chk(v === 8, "R7 held period readable", v, 8);
        wr(A_CTL, 32'h13);
        u = cyc;
        nb = u + 1;
        while ((nb - c0) % 4 != 0) nb++;
        while (cyc < u + 24) begin
            bit e;
            e = (cyc < nb) ? expo(cyc - c0, 4, 1, 1, 0) : expo(cyc - nb, 8, 5, 0, 1);
            chk(pwm_out === e, "R8 release at wrap", pwm_out, e);
            @(negedge clk);
        end
        rd(A_CNT, v, at);
        chk(v === (at - nb) % 8, "R8 counter new period", v, (at - nb) % 8);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule